// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

This unit sits between one bus master and a single-port, word-wide SRAM that the system maps at 0x2000_0000. A second window, starting at 0x2200_0000, is an alias space. Each 32-bit-aligned alias word in that window stands for exactly one bit of the SRAM. The alias address is the alias base plus thirty-two times the byte offset into the SRAM, plus four times the bit number inside that byte. A read of an alias returns the selected bit alone. A write of an alias replaces only that bit. The unit does this as one indivisible read-modify-write on the SRAM, so software never has to mask and merge a word itself.

Any address outside the alias window goes straight to the SRAM as an ordinary word access. Its word index is taken from the address bits above the two byte bits. The master port uses a request/ready handshake. A transfer is accepted on a clock edge where `m_req` and `m_ready` are both high. Read data comes back with `m_rvalid` one cycle after acceptance, because the SRAM has a one-cycle read latency. An alias write keeps `m_ready` low for exactly one extra cycle, during which the merged word is written back. The master cannot issue any other access until that write-back is done.

Top module: `bitband_unit`

## Requirements
- R1: After reset, with no request pending, `m_ready` is 1, and `m_rvalid` and `sram_en` are 0.
- R2: A non-alias access is forwarded in its acceptance cycle: `sram_en`=1, `sram_we`=`m_we`, `sram_wdata`=`m_wdata`, `sram_addr`=`m_addr[SRAM_AW+1:2]`. A direct read returns the full stored word.
- R3: For an alias address A, let d = A − 0x2200_0000. The byte offset is d>>5, and the bit number is (d>>2)&7. The SRAM word is byte offset>>2. The bit lane inside that word is 8×(byte offset mod 4) + bit number, little-endian. Example: alias 0x2202_000C selects bit 3 of byte 0x1000, which is word 0x400, lane 3.
- R4: An alias read puts the selected bit in `m_rdata[0]`, with bits 31..1 zero, and asserts `m_rvalid` one cycle after acceptance.
- R5: An alias write sets the selected bit to `m_wdata[0]`. Bits 31..1 of `m_wdata` are ignored, and every other bit of the SRAM word keeps its value.
- R6: After an alias write is accepted, `m_ready` is 0 for exactly the next cycle and 1 in the cycle after that.
- R7: Direct accesses and alias reads never drop `m_ready`, so they can be issued back to back, one per cycle.
- R8: The window's size is 32 times the SRAM byte size (0x4_0000 for the default 2048 words). Addresses just below the window (0x21FF_FFFC) are direct accesses, and so are addresses at or past its end (0x2204_0000).
- R9: The read-modify-write reads the word in the acceptance cycle (`sram_we`=0). In the next cycle it writes the merged word back to the same SRAM address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_req | input | 1 | Master request |
| m_we | input | 1 | Master write (1) / read (0) |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_ready | output | 1 | Unit can accept a request this cycle |
| m_rvalid | output | 1 | Read data valid (one cycle after read acceptance) |
| m_rdata | output | 32 | Read data |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | SRAM_AW | SRAM word address |
| sram_wdata | output | 32 | SRAM write data |
| sram_rdata | input | 32 | SRAM read data, one cycle after a read |

## Verification
The bench sweeps every one of the 32 lanes of the first words, the middle word and the last word, for both alias reads and alias writes. A lane formula with the byte and bit fields swapped would therefore return or change the wrong bit. Alias writes carry junk in data bits 31..1 and flip the target bit, and each word is then read back directly. A merge that used the whole write data, or that cleared neighbouring bits, would corrupt the stored word. The documented 0x2202_000C case is checked on its own. Addresses one word below the window and exactly at its end are checked as direct accesses, which catches an off-by-one window compare. The bench also checks that ready drops for exactly one cycle after each alias write, and that direct accesses run back to back.

// File: rtl/bb_pkg.sv
// Shared definitions for the bit-band alias unit.
// Assumes a 32-bit data path; the alias stride formula depends on it.
package bb_pkg;
    localparam int DATA_W = 32;
    localparam int LANE_W = 5;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WBACK = 1'b1
    } bb_state_e;
endpackage

// File: rtl/bb_decode.sv
// Address decoder: classifies an address as alias or direct and yields the
// SRAM word index and the bit lane inside that word.
// Assumes the alias window covers the whole SRAM (2^SRAM_AW words).
module bb_decode #(
    parameter int          ADDR_W     = 32,
    parameter int          SRAM_AW    = 11,
    parameter logic [31:0] ALIAS_BASE = 32'h2200_0000
) (
    input  logic [ADDR_W-1:0]        addr,
    output logic                     is_alias,
    output logic [SRAM_AW-1:0]       word_idx,
    output logic [bb_pkg::LANE_W-1:0] lane
);
    // Window span in bytes: 4 bytes per word, 32 alias bytes per SRAM byte.
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(1) << (SRAM_AW + 7);

    logic [ADDR_W-1:0] offs;
    logic              unused_low;

    // Offset into the alias window and window membership test.
    always_comb begin
        offs     = addr - ADDR_W'(ALIAS_BASE);
        is_alias = (addr >= ADDR_W'(ALIAS_BASE)) && (offs < SPAN);
    end

    // Word index and lane: alias takes byte=offs>>5, bit=offs[4:2].
    always_comb begin
        if (is_alias) begin
            word_idx = offs[SRAM_AW+6:7];
            lane     = {offs[6:5], offs[4:2]};
        end else begin
            word_idx = addr[SRAM_AW+1:2];
            lane     = '0;
        end
    end

    assign unused_low = ^offs[1:0];
endmodule

// File: rtl/bb_merge.sv
// Bit lane insert/extract: replaces one bit of a word and picks one bit out.
// Purely combinational; lane must be below DATA_W.
module bb_merge #(
    parameter int DATA_W = bb_pkg::DATA_W,
    parameter int LANE_W = bb_pkg::LANE_W
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [LANE_W-1:0] lane,
    input  logic              bit_val,
    output logic [DATA_W-1:0] word_out,
    output logic              bit_out
);
    logic [DATA_W-1:0] sel_mask;

    // Build the single-bit mask and merge the new value into it.
    always_comb begin
        sel_mask = {{(DATA_W-1){1'b0}}, 1'b1} << lane;
        word_out = (word_in & ~sel_mask) | ({DATA_W{bit_val}} & sel_mask);
        bit_out  = word_in[lane];
    end
endmodule

// File: rtl/bb_ctrl.sv
// Sequencer: holds the per-access context across the SRAM latency and runs
// the one-cycle write-back state of an alias read-modify-write.
// Assumes the SRAM returns read data exactly one cycle after the read.
module bb_ctrl #(
    parameter int SRAM_AW = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      accept,
    input  logic                      we,
    input  logic                      is_alias,
    input  logic [SRAM_AW-1:0]        word_idx,
    input  logic [bb_pkg::LANE_W-1:0] lane,
    input  logic                      new_bit,
    output logic                      ready,
    output logic                      wback,
    output logic                      rd_pend,
    output logic                      rd_alias,
    output logic [SRAM_AW-1:0]        hold_word,
    output logic [bb_pkg::LANE_W-1:0] hold_lane,
    output logic                      hold_bit
);
    import bb_pkg::*;

    bb_state_e state;

    // State: an accepted alias write spends one cycle in write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (state == ST_WBACK) begin
            state <= ST_IDLE;
        end else if (accept && we && is_alias) begin
            state <= ST_WBACK;
        end
    end

    // Pending-read flags for the response one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend  <= 1'b0;
            rd_alias <= 1'b0;
        end else begin
            rd_pend  <= accept && !we;
            rd_alias <= accept && !we && is_alias;
        end
    end

    // Access context captured on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word <= '0;
            hold_lane <= '0;
            hold_bit  <= 1'b0;
        end else if (accept) begin
            hold_word <= word_idx;
            hold_lane <= lane;
            hold_bit  <= new_bit;
        end
    end

    assign ready = (state == ST_IDLE);
    assign wback = (state == ST_WBACK);
endmodule

// File: rtl/bitband_unit.sv
// Bit-band alias access unit top: decodes master accesses, forwards direct
// ones to the SRAM and turns alias ones into single-bit reads or atomic
// read-modify-writes. Assumes a single-port SRAM with one-cycle read latency.
module bitband_unit #(
    parameter int          SRAM_AW    = 11,
    parameter logic [31:0] ALIAS_BASE = 32'h2200_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               m_req,
    input  logic               m_we,
    input  logic [31:0]        m_addr,
    input  logic [31:0]        m_wdata,
    output logic               m_ready,
    output logic               m_rvalid,
    output logic [31:0]        m_rdata,
    output logic               sram_en,
    output logic               sram_we,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [31:0]        sram_wdata,
    input  logic [31:0]        sram_rdata
);
    import bb_pkg::*;

    logic               dec_alias;
    logic [SRAM_AW-1:0] dec_word;
    logic [LANE_W-1:0]  dec_lane;
    logic               accept;
    logic               wback;
    logic               rd_alias;
    logic [SRAM_AW-1:0] hold_word;
    logic [LANE_W-1:0]  hold_lane;
    logic               hold_bit;
    logic [DATA_W-1:0]  merged;
    logic               picked;

    bb_decode #(
        .ADDR_W    (32),
        .SRAM_AW   (SRAM_AW),
        .ALIAS_BASE(ALIAS_BASE)
    ) u_decode (
        .addr    (m_addr),
        .is_alias(dec_alias),
        .word_idx(dec_word),
        .lane    (dec_lane)
    );

    bb_ctrl #(
        .SRAM_AW(SRAM_AW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .we       (m_we),
        .is_alias (dec_alias),
        .word_idx (dec_word),
        .lane     (dec_lane),
        .new_bit  (m_wdata[0]),
        .ready    (m_ready),
        .wback    (wback),
        .rd_pend  (m_rvalid),
        .rd_alias (rd_alias),
        .hold_word(hold_word),
        .hold_lane(hold_lane),
        .hold_bit (hold_bit)
    );

    bb_merge #(
        .DATA_W(DATA_W),
        .LANE_W(LANE_W)
    ) u_merge (
        .word_in (sram_rdata),
        .lane    (hold_lane),
        .bit_val (hold_bit),
        .word_out(merged),
        .bit_out (picked)
    );

    assign accept = m_req && m_ready;

    // SRAM port: write-back has priority, else the master request drives it.
    always_comb begin
        if (wback) begin
            sram_en    = 1'b1;
            sram_we    = 1'b1;
            sram_addr  = hold_word;
            sram_wdata = merged;
        end else begin
            sram_en    = m_req;
            sram_we    = m_we && !dec_alias;
            sram_addr  = dec_word;
            sram_wdata = m_wdata;
        end
    end

    // Read response: alias reads return the single bit in position 0.
    always_comb begin
        if (rd_alias) begin
            m_rdata = {{(DATA_W-1){1'b0}}, picked};
        end else begin
            m_rdata = sram_rdata;
        end
    end
endmodule

// File: rtl/bb_checker.sv
// Property checker for bitband_unit, attached by bind below.
// Observes ports plus the decoder's alias flag.
module bb_checker #(
    parameter int SRAM_AW = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               m_req,
    input logic               m_we,
    input logic [31:0]        m_wdata,
    input logic               m_ready,
    input logic               m_rvalid,
    input logic [31:0]        m_rdata,
    input logic               is_alias,
    input logic               sram_en,
    input logic               sram_we,
    input logic [SRAM_AW-1:0] sram_addr,
    input logic [31:0]        sram_wdata,
    input logic [31:0]        sram_rdata
);
    assert_direct_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ready && !is_alias) |-> (sram_en && sram_we == m_we && sram_wdata == m_wdata));

    assert_alias_zero_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ready && !m_we && is_alias) |=> (m_rvalid && m_rdata[31:1] == 31'd0));

    assert_one_bit_changed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !m_ready |-> ($countones(sram_wdata ^ sram_rdata) <= 1));

    assert_wback_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ready && m_we && is_alias) |=> !m_ready);

    assert_stall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !m_ready |=> m_ready);

    assert_read_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ready && !(m_we && is_alias)) |=> (m_ready && (m_rvalid == !$past(m_we))));

    assert_rmw_read_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ready && m_we && is_alias) |-> (sram_en && !sram_we));

    assert_rmw_same_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !m_ready |-> (sram_en && sram_we && sram_addr == $past(sram_addr)));
endmodule

bind bitband_unit bb_checker #(.SRAM_AW(SRAM_AW)) u_bb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_req     (m_req),
    .m_we      (m_we),
    .m_wdata   (m_wdata),
    .m_ready   (m_ready),
    .m_rvalid  (m_rvalid),
    .m_rdata   (m_rdata),
    .is_alias  (dec_alias),
    .sram_en   (sram_en),
    .sram_we   (sram_we),
    .sram_addr (sram_addr),
    .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata)
);

// File: tb/bitband_unit_bench.sv
`timescale 1ns/1ps
module bitband_unit_bench;
    localparam int AW    = 11;
    localparam int WORDS = 1 << AW;
    localparam logic [31:0] ABASE = 32'h2200_0000;
    localparam logic [31:0] DBASE = 32'h2000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            m_req = 1'b0;
    logic            m_we = 1'b0;
    logic [31:0]     m_addr = '0;
    logic [31:0]     m_wdata = '0;
    logic            m_ready;
    logic            m_rvalid;
    logic [31:0]     m_rdata;
    logic            sram_en;
    logic            sram_we;
    logic [AW-1:0]   sram_addr;
    logic [31:0]     sram_wdata;
    logic [31:0]     sram_rdata;

    logic [31:0] mem [WORDS];
    logic [31:0] expw [WORDS];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bitband_unit #(.SRAM_AW(AW), .ALIAS_BASE(ABASE)) u_bitband_unit (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_ready(m_ready), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
        .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    // SRAM model: one-cycle read latency.
    always_ff @(posedge clk) begin
        if (sram_en) begin
            if (sram_we) mem[sram_addr] <= sram_wdata;
            else         sram_rdata <= mem[sram_addr];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One transfer; returns ready/rvalid/rdata seen one cycle after acceptance.
    task automatic xfer(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] q, output logic rv, output logic rdy1);
        @(negedge clk);
        while (!m_ready) @(negedge clk);
        m_req = 1'b1; m_we = we; m_addr = a; m_wdata = d;
        @(negedge clk);
        m_req = 1'b0; m_we = 1'b0;
        rdy1 = m_ready; rv = m_rvalid; q = m_rdata;
    endtask

    function automatic logic [31:0] pattern(input int w);
        return (32'(w) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] alias_of(input int w, input int lane);
        return ABASE + 32'(w) * 32'd128 + 32'(lane) * 32'd4;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        logic rv, rdy;
        int words_t [4] = '{0, 1, 32'h400, WORDS - 1};

        for (int i = 0; i < WORDS; i++) begin mem[i] = '0; expw[i] = '0; end
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        check("R1 ready", 32'(m_ready), 32'd1);
        check("R1 rvalid", 32'(m_rvalid), 32'd0);
        check("R1 sram_en", 32'(sram_en), 32'd0);

        // R2: direct writes then direct reads of full words
        foreach (words_t[k]) begin
            xfer(1'b1, DBASE + 32'(words_t[k]) * 4, pattern(words_t[k]), q, rv, rdy);
            expw[words_t[k]] = pattern(words_t[k]);
            check("R7 ready after direct write", 32'(rdy), 32'd1);
        end
        foreach (words_t[k]) begin
            xfer(1'b0, DBASE + 32'(words_t[k]) * 4, 32'h0, q, rv, rdy);
            check("R2 direct read valid", 32'(rv), 32'd1);
            check("R2 direct read data", q, expw[words_t[k]]);
        end

        // R7: two direct reads back to back
        @(negedge clk);
        m_req = 1'b1; m_we = 1'b0; m_addr = DBASE + 32'h4;
        @(negedge clk);
        check("R7 ready stays high", 32'(m_ready), 32'd1);
        check("R7 first read", m_rdata, expw[1]);
        m_addr = DBASE + 32'h1000;
        @(negedge clk);
        m_req = 1'b0;
        check("R7 second read valid", 32'(m_rvalid), 32'd1);
        check("R7 second read", m_rdata, expw[32'h400]);

        // R3/R4: alias read sweep over every lane
        foreach (words_t[k]) begin
            for (int ln = 0; ln < 32; ln++) begin
                xfer(1'b0, alias_of(words_t[k], ln), 32'h0, q, rv, rdy);
                check("R4 alias read valid", 32'(rv), 32'd1);
                check("R3 R4 alias read bit", q, 32'((expw[words_t[k]] >> ln) & 1));
            end
        end

        // R5/R6/R9: alias write sweep flipping each bit, junk in upper data
        foreach (words_t[k]) begin
            for (int ln = 0; ln < 32; ln++) begin
                logic nb;
                nb = ~expw[words_t[k]][ln];
                xfer(1'b1, alias_of(words_t[k], ln),
                     {31'h2AAA_5555 ^ 31'(ln * 7919), nb}, q, rv, rdy);
                check("R6 ready low after alias write", 32'(rdy), 32'd0);
                @(negedge clk);
                check("R6 ready back", 32'(m_ready), 32'd1);
                expw[words_t[k]][ln] = nb;
                xfer(1'b0, alias_of(words_t[k], ln), 32'h0, q, rv, rdy);
                check("R5 alias write bit", q, 32'(nb));
            end
            xfer(1'b0, DBASE + 32'(words_t[k]) * 4, 32'h0, q, rv, rdy);
            check("R5 R9 word after alias writes", q, expw[words_t[k]]);
        end

        // R3: documented example, bit 3 of byte 0x1000
        xfer(1'b1, DBASE + 32'h1000, 32'h0, q, rv, rdy);
        xfer(1'b1, 32'h2202_000C, 32'hFFFF_FFFF, q, rv, rdy);
        xfer(1'b0, DBASE + 32'h1000, 32'h0, q, rv, rdy);
        check("R3 example word", q, 32'h0000_0008);
        xfer(1'b0, 32'h2202_000C, 32'h0, q, rv, rdy);
        check("R3 example read", q, 32'h1);
        xfer(1'b1, 32'h2202_0004, 32'hFFFF_FFFE, q, rv, rdy);
        xfer(1'b0, DBASE + 32'h1000, 32'h0, q, rv, rdy);
        check("R5 clear with junk upper bits", q, 32'h0000_0008);
        expw[32'h400] = 32'h8;

        // R8: window boundaries
        xfer(1'b1, ABASE + 32'h0004_0000, 32'hCAFE_1234, q, rv, rdy);
        check("R8 end of window is direct (no stall)", 32'(rdy), 32'd1);
        xfer(1'b0, DBASE, 32'h0, q, rv, rdy);
        check("R8 end of window wrote word 0", q, 32'hCAFE_1234);
        xfer(1'b1, ABASE - 32'h4, 32'h1357_9BDF, q, rv, rdy);
        xfer(1'b0, DBASE + 32'(WORDS - 1) * 4, 32'h0, q, rv, rdy);
        check("R8 below window wrote last word", q, 32'h1357_9BDF);
        xfer(1'b0, ABASE + 32'h0003_FFFC, 32'h0, q, rv, rdy);
        check("R8 last alias is bit 31 of last word", q, 32'h0);
        xfer(1'b0, ABASE + 32'h0003_FFF0, 32'h0, q, rv, rdy);
        check("R8 alias bit 28 of last word", q, 32'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule